// File: doc/BRIEF.md
# SPI master frame sequencer

This block is a synchronous serial master. Software-side logic pushes words into a small transmit queue. The sequencer shifts each word out most significant bit first, and each word it receives goes into a receive queue. The serial clock idles high. Input data is sampled on each falling clock edge, and output data moves on each rising edge. A divider sets the half-bit period in system clocks, and the word length can be set anywhere from 4 to 16 bits.

Each frame follows a fixed edge schedule. First the select line drops. Half a period later the first data bit appears. Half a period after that the clock makes its first falling edge. After the last capture the clock rises half a period later, and the select returns high one full period after that capture. If the next transmit word is already queued when the last bit of a word is sampled, the select stays low. The next word's first bit then goes out on that same rising edge, and the clock runs on without a gap.

Top module: `spi_fss_master`

## Requirements
- R1: Out of reset and whenever no frame is active, cs_no = 1, sclk_o = 1, mosi_o = 0 and mosi_oe_o = 0. sclk_oe_o is always 1.
- R2: A frame begins, with cs_no falling, only when en_i = 1 and the transmit queue is not empty. mosi_o is still 0 in the cycle the select falls.
- R3: Exactly H system clocks after cs_no falls, mosi_o carries bit (L-1) of the first word. H = max(div_i, 2) and L is the effective word length.
- R4: The first falling edge of sclk_o comes 2H clocks after cs_no falls. Each rising edge follows the previous falling edge by H clocks, and consecutive falling edges are 2H clocks apart.
- R5: miso_i is sampled on falling edges of sclk_o, and mosi_o never changes in a cycle where sclk_o falls. Bits go out and come in MSB first.
- R6: The effective word length L is wlen_i clamped to the range 4..16. Values below 4 act as 4, and values above 16 act as 16.
- R7: When no next word is queued at the last sample, sclk_o rises H clocks after that sample. cs_no rises 2H clocks after it, and mosi_o returns to 0 at that same moment.
- R8: When the next word is present and en_i = 1 at the last sample of a word, cs_no stays low, and the next word's MSB is driven on the following rising edge. A burst of queued words therefore forms a single frame.
- R9: Each received word is stored right-justified with zeros above bit L-1. Received words leave the receive queue in arrival order, and rx_valid_o = 1 while it holds data.
- R10: A word that completes while the receive queue is full is discarded, and overrun_o goes to 1 and stays there until reset.
- R11: busy_o = 1 from the cycle cs_no falls to the cycle it rises.
- R12: tx_ready_o = 0 while the transmit queue (4 entries) is full. A write offered then is ignored and is never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows new frames and word chaining |
| div_i | input | 8 | Half-bit period in system clocks (min 2) |
| wlen_i | input | 5 | Word length in bits (clamped 4..16) |
| tx_data_i | input | 16 | Transmit word, right-justified |
| tx_valid_i | input | 1 | Transmit write strobe |
| tx_ready_o | output | 1 | Transmit queue has room |
| rx_data_o | output | 16 | Head of receive queue |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_ready_i | input | 1 | Pop receive head |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Serial clock driver enable |
| cs_no | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Serial data driver enable |
| busy_o | output | 1 | Frame in progress |
| overrun_o | output | 1 | Sticky receive-drop flag |

## Verification
The assertions check several relations on every cycle. While the select is high the clock stays high and the data line stays low. The data output holds still across falling clock edges. A frame opens only when enabled. busy_o matches the select. The queues never go past their depth, and overrun_o rises only after a push into a full receive queue. The exact half-period distances between edges are shown by the bench's sweep over word lengths and dividers, which measures them in cycles. The same sweep shows that bursts merge into one frame and that the bit content matches in both directions.

// File: rtl/spi_fss_pkg.sv
package spi_fss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/spi_fss_fifo.sv
module spi_fss_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o && $stable(wr_q)); // R12
  AST_FIFO_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R12
endmodule

// File: rtl/spi_fss_halfbit_timer.sv
module spi_fss_halfbit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  // half period never shorter than two system clocks
  assign div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign tick_o  = run_i && (cnt_q == div_eff - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/spi_fss_engine.sv
module spi_fss_engine
  import spi_fss_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WLEN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              tick_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              miso_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              run_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int MIN_W = 4;

  seq_state_e        state_q;
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-2:0] rx_sh_q;
  logic              cont_q;
  logic [WLEN_W-1:0] wlen_eff;
  logic [IDX_W-1:0]  idx_load;
  logic              start, reload, last_bit;

  always_comb begin
    if (wlen_i < WLEN_W'(MIN_W))       wlen_eff = WLEN_W'(MIN_W);
    else if (wlen_i > WLEN_W'(DATA_W)) wlen_eff = WLEN_W'(DATA_W);
    else                               wlen_eff = wlen_i;
  end
  assign idx_load = IDX_W'(wlen_eff - 1'b1);

  assign last_bit  = (idx_q == '0);
  assign start     = (state_q == ST_IDLE) && en_i && !tx_empty_i;
  assign reload    = (state_q == ST_LOW) && tick_i && last_bit && cont_q;
  assign tx_pop_o  = start || reload;
  assign rx_push_o = (state_q == ST_HIGH) && tick_i && last_bit;
  assign rx_data_o = {rx_sh_q, miso_i};
  assign run_o     = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      idx_q   <= '0;
      rx_sh_q <= '0;
      cont_q  <= 1'b0;
      cs_no   <= 1'b1;
      sclk_o  <= 1'b1;
      mosi_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          word_q  <= tx_data_i;
          idx_q   <= idx_load;
          rx_sh_q <= '0;
          cs_no   <= 1'b0;
          state_q <= ST_LEAD;
        end
        ST_LEAD: if (tick_i) begin
          mosi_o  <= word_q[idx_q];
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick_i) begin
          sclk_o  <= 1'b0;
          rx_sh_q <= {rx_sh_q[DATA_W-3:0], miso_i};
          if (last_bit) cont_q <= en_i && !tx_empty_i;
          state_q <= ST_LOW;
        end
        ST_LOW: if (tick_i) begin
          sclk_o <= 1'b1;
          if (!last_bit) begin
            idx_q   <= idx_q - 1'b1;
            mosi_o  <= word_q[idx_q - 1'b1];
            state_q <= ST_HIGH;
          end else if (cont_q) begin
            // chain: next MSB goes out on this rising edge
            word_q  <= tx_data_i;
            idx_q   <= idx_load;
            mosi_o  <= tx_data_i[idx_load];
            rx_sh_q <= '0;
            state_q <= ST_HIGH;
          end else begin
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: if (tick_i) begin
          cs_no   <= 1'b1;
          mosi_o  <= 1'b0;
          cont_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o); // R1
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !mosi_o); // R1
  AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(en_i) && !mosi_o); // R2
  AST_MOSI_HOLD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(mosi_o)); // R5
endmodule

// File: rtl/spi_fss_master.sv
module spi_fss_master #(
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int WLEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              busy_o,
  output logic              overrun_o
);
  logic              tx_full, tx_empty, tx_pop;
  logic [DATA_W-1:0] tx_head;
  logic              rx_full, rx_empty, rx_push;
  logic [DATA_W-1:0] rx_word;
  logic              tick, run;
  logic              overrun_q;

  spi_fss_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .din_i   (tx_data_i),
    .pop_i   (tx_pop),
    .dout_o  (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_fss_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .din_i   (rx_word),
    .pop_i   (rx_ready_i),
    .dout_o  (rx_data_o),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  spi_fss_halfbit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi_fss_engine #(.DATA_W(DATA_W), .WLEN_W(WLEN_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .wlen_i     (wlen_i),
    .tick_i     (tick),
    .tx_empty_i (tx_empty),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .miso_i     (miso_i),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_word),
    .run_o      (run),
    .cs_no      (cs_no),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overrun_q <= 1'b0;
    else if (rx_push && rx_full) overrun_q <= 1'b1;
  end

  assign tx_ready_o = !tx_full;
  assign rx_valid_o = !rx_empty;
  assign sclk_oe_o  = 1'b1;
  assign mosi_oe_o  = !cs_no;
  assign busy_o     = run;
  assign overrun_o  = overrun_q;

  AST_OVERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_full)); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R10
  AST_BUSY_TRACKS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_no); // R11
endmodule

// File: tb/spi_fss_master_tb.sv
module spi_fss_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div = 8'd2;
  logic [4:0]  wlen = 5'd8;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, sclk_oe, cs_n, mosi, mosi_oe, busy, overrun;

  always #5 clk = ~clk;

  spi_fss_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .wlen_i(wlen),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .miso_i(miso), .sclk_o(sclk), .sclk_oe_o(sclk_oe), .cs_no(cs_n),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .busy_o(busy), .overrun_o(overrun)
  );

  int n_run = 0, n_fail = 0;
  int wl = 8, hb = 2;
  int cyc = 0;
  int frames = 0, words_done = 0;
  int exp_tx [4096];
  int tx_wr = 0, tx_rd = 0;
  int rx_exp [4096];
  int rx_wr = 0, rx_rd = 0, rx_occ = 0;
  int sw_idx = 0, bits = 0, got = 0;
  int t_cs = 0, t_fall = 0;
  bit first_fall = 0, lead_pending = 0;
  bit prev_cs = 1, prev_sclk = 1;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int mask_of(input int w);
    return (1 << w) - 1;
  endfunction

  function automatic int slave_word(input int k, input int w);
    int v;
    v = (k * 32'h9A37) ^ 32'h05C1;
    return v & mask_of(w);
  endfunction

  // cycle-counting line monitor and slave model, sampled at falling clk
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        frames++;
        t_cs = cyc;
        first_fall = 1;
        lead_pending = 1;
        bits = 0;
        got = 0;
        check(mosi == 1'b0, "R2 mosi low as select falls", mosi, 0);
        check(busy == 1'b1 && mosi_oe == 1'b1, "R11 busy/driver at select fall", {busy, mosi_oe}, 3);
        miso = slave_word(sw_idx, wl)[wl-1];
      end
      if (lead_pending && !cs_n && cyc == t_cs + hb) begin
        lead_pending = 0;
        check(mosi == exp_tx[tx_rd][wl-1], "R3 first bit after half period", mosi, exp_tx[tx_rd][wl-1]);
      end
      if (prev_sclk && !sclk) begin
        if (first_fall)
          check(cyc - t_cs == 2*hb, "R4 first fall delay", cyc - t_cs, 2*hb);
        else
          check(cyc - t_fall == 2*hb, "R4 fall spacing", cyc - t_fall, 2*hb);
        first_fall = 0;
        t_fall = cyc;
        got = (got << 1) | int'(mosi);
        bits++;
        if (bits == wl) begin
          check(got == exp_tx[tx_rd], "R5 R6 shifted word", got, exp_tx[tx_rd]);
          tx_rd++;
          if (rx_occ < 4) begin
            rx_exp[rx_wr] = slave_word(sw_idx, wl);
            rx_wr++;
            rx_occ++;
          end
          sw_idx++;
          words_done++;
          bits = 0;
          got = 0;
        end
      end
      if (!prev_sclk && sclk && !cs_n) begin
        check(cyc - t_fall == hb, "R4 rise after fall", cyc - t_fall, hb);
        miso = slave_word(sw_idx, wl)[wl-1-bits];
      end
      if (!prev_cs && cs_n) begin
        check(cyc - t_fall == 2*hb, "R7 select rise delay", cyc - t_fall, 2*hb);
        check(mosi == 1'b0 && sclk == 1'b1 && busy == 1'b0, "R7 R11 lines at end", {mosi, sclk, busy}, 2);
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic push(input int d);
    @(negedge clk);
    if (tx_ready) begin
      exp_tx[tx_wr] = d & mask_of(wl);
      tx_wr++;
    end
    tx_data = 16'(d);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_words(input int n);
    while (words_done < n) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rx_valid == 1'b1, "R9 rx word present", rx_valid, 1);
      check(int'(rx_data) == rx_exp[rx_rd], "R9 rx word value", rx_data, rx_exp[rx_rd]);
      rx_rd++;
      rx_occ--;
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  endtask

  task automatic set_cfg(input int d, input int w);
    div = 8'(d);
    wlen = 5'(w);
    hb = (d < 2) ? 2 : d;
    wl = (w < 4) ? 4 : (w > 16 ? 16 : w);
  endtask

  initial begin
    int divs [3] = '{1, 3, 5};
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cs_n == 1 && sclk == 1 && mosi == 0 && mosi_oe == 0, "R1 idle lines", {cs_n, sclk, mosi, mosi_oe}, 12);
    check(sclk_oe == 1 && busy == 0 && tx_ready == 1 && rx_valid == 0 && overrun == 0,
          "R1 idle status", {sclk_oe, busy, tx_ready, rx_valid, overrun}, 5'b10100);

    // R12 / R2: fill queue while disabled
    set_cfg(2, 8);
    for (int i = 0; i < 4; i++) push(16'hA50 + i * 16'h111);
    check(tx_ready == 1'b0, "R12 ready low when full", tx_ready, 0);
    push(16'h00FF);
    repeat (40) @(negedge clk);
    check(frames == 0 && busy == 0 && cs_n == 1, "R2 no frame while disabled", frames, 0);
    en = 1'b1;
    wait_words(4);
    check(frames == 1, "R8 R12 four queued words in one frame", frames, 1);
    check(words_done == 4, "R12 rejected write never sent", words_done, 4);
    check(overrun == 1'b0, "R10 no overrun yet", overrun, 0);
    push(16'h003C);
    wait_words(5);
    check(overrun == 1'b1, "R10 overrun set on full queue", overrun, 1);
    drain(4);
    @(negedge clk);
    check(rx_valid == 1'b0, "R10 dropped word absent", rx_valid, 0);
    check(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

    // sweep word length and divider: single then chained burst
    foreach (divs[di]) begin
      for (int w = 2; w <= 17; w++) begin
        set_cfg(divs[di], w);
        f0 = frames;
        push(16'hC3A5 ^ (w * 16'h0F1) ^ (di * 16'h1234));
        wait_words(words_done + 1);
        check(frames == f0 + 1, "R7 single word frame", frames - f0, 1);
        drain(1);
        f0 = frames;
        push(16'h5A5A + w);
        push(16'hFFFF - w * 3);
        push(16'h8001 + (w << 4));
        wait_words(words_done + 3);
        check(frames == f0 + 1, "R8 burst stays in one frame", frames - f0, 1);
        drain(3);
      end
    end

    // R8: word queued only after the frame ended gives a new frame
    set_cfg(3, 6);
    f0 = frames;
    push(16'h0015);
    wait_words(words_done + 1);
    push(16'h002A);
    wait_words(words_done + 1);
    check(frames == f0 + 2, "R8 late word opens new frame", frames - f0, 2);
    drain(2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule